// File: doc/BRIEF.md
# Burst Order and Write-Mask Generator

This block sits in the column path of a fast-cycle DRAM controller and works out, for each two- or four-word access, the order in which the words inside the column group are visited and which of them are actually written. It runs at double data rate: every clock it presents a pair of beats, the word offset and write enable for the rising-edge beat and for the falling-edge beat.

The burst length and burst type come from mode settings that are already held elsewhere. A read or write strobe marks the clock in which the second half of an access command is sampled. Along with that strobe come the two low column-address bits and, for writes, a two-bit variable-write code. The code shortens a write to its first one, first two or all of its words. The words that are masked are always the last ones in burst order. Write beats appear a fixed write latency after the strobe, and read beats a fixed read latency after it. Setting combinations that are not defined raise an error flag and suppress every write enable of that access.

Top module: `burst_order_gen`

## Requirements
- R1: The burst-length code `bl_code` selects 2 words for 3'b001 and 4 words for 3'b010. A 2-word burst fills one clock (one pair). A 4-word burst fills two consecutive clocks: beats 0 and 1, then beats 2 and 3. Any other code is reserved: it gives one pair with both enables low and `cfg_err` high.
- R2: With `burst_il` = 0 (sequential order), beat i of a 4-word burst has offset (start + i) mod 4. For a 2-word burst, bit 1 of the start is kept and bit 0 is start[0] + i mod 2.
- R3: With `burst_il` = 1 (interleaved order), beat i has offset start XOR i, with i in 0..length-1.
- R4: For a 2-word write, `vw0` = 0 writes both words and `vw0` = 1 writes only the first word. `vw1` has no effect.
- R5: For a 4-word write, the code ({vw1,vw0}) has these meanings: 2'b01 writes all four words, 2'b10 writes the first two, 2'b11 writes only the first, and 2'b00 is reserved.
- R6: Masking follows burst order, not address order. The written beats are always a leading run of the burst. For example, a sequential 4-word first-word-only write starting at offset 1 enables offset 1 and masks offsets 2, 3 and 0.
- R7: Take the clock in which a strobe is sampled as cycle c. The first pair of a write is presented in cycle c+4, and the first pair of a read in cycle c+5. No beat is presented in the cycle before. A read followed by a write three clocks later gives four back-to-back pairs that do not interfere.
- R8: Read beats carry `beat_wr` = 0 and both enables low. A read raises `cfg_err` only for a reserved burst length.
- R9: A 4-word write with the reserved variable-write code raises `cfg_err` on its first pair, and all of its enables are low.
- R10: During and right after synchronous active-low reset, `beat_valid`, `beat_wr`, both enables and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat pair per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bl_code | input | 3 | Latched burst-length code |
| burst_il | input | 1 | Latched burst type: 0 sequential, 1 interleaved |
| cmd_rd | input | 1 | Read access strobe (second command half) |
| cmd_wr | input | 1 | Write access strobe (second command half) |
| col_lo | input | 2 | Starting word offset within the column group |
| vw0 | input | 1 | Variable-write code bit 0 |
| vw1 | input | 1 | Variable-write code bit 1 |
| beat_valid | output | 1 | A beat pair is presented this cycle |
| beat_wr | output | 1 | Presented pair belongs to a write |
| off_a | output | 2 | Word offset of the rising-edge beat |
| off_b | output | 2 | Word offset of the falling-edge beat |
| we_a | output | 1 | Write enable of the rising-edge beat |
| we_b | output | 1 | Write enable of the falling-edge beat |
| cfg_err | output | 1 | Reserved setting on this access (first pair) |

## Verification
Suppose a job is placed in the wrong stage of the latency line. The first pair then shows up one clock early or late, and the cycle checked before the expected one catches it at once. A wrong pending second-half register shows up in the clock after the first pair: either a missing second pair or offsets repeated from the first pair. Errors in order or mask decoding appear in the very first presented pair. The bench covers every burst length, burst type, start offset, variable-write code and direction, so a single bad table entry cannot go unseen.

// File: rtl/bo_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst order generator.
// Assumes bursts of at most BEATS words inside a 2^OFF_W word column group.
package bo_pkg;
    localparam int BEATS = 4;
    localparam int OFF_W = 2;
    localparam int CNT_W = 3;

    // One decoded access travelling down the latency line.
    typedef struct packed {
        logic                        valid;
        logic                        wr;
        logic                        err;
        logic                        bl4;
        logic [BEATS-1:0][OFF_W-1:0] off;
        logic [BEATS-1:0]            we;
    } bo_job_t;
endpackage

// File: rtl/bo_decode.sv
`timescale 1ns/1ps
// Combinational decode of one access: beat offsets, per-beat write enables
// and the reserved-setting error. Assumes at most one of cmd_rd/cmd_wr is
// high; if both are high the access is treated as a write.
module bo_decode
    import bo_pkg::*;
(
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [2:0]       bl_code,
    input  logic             burst_il,
    input  logic [OFF_W-1:0] col_lo,
    input  logic             vw0,
    input  logic             vw1,
    output bo_job_t          job
);
    localparam logic [2:0] BL_TWO  = 3'b001;
    localparam logic [2:0] BL_FOUR = 3'b010;

    logic                        acc;
    logic                        bl_ok;
    logic                        bl4;
    logic                        vw_bad;
    logic                        err;
    logic                        wr_ok;
    logic [CNT_W-1:0]            n_wr;
    logic [BEATS-1:0][OFF_W-1:0] off_calc;
    logic [BEATS-1:0]            we_calc;

    // Classify the settings and count the words a write may touch.
    always_comb begin
        acc    = cmd_rd | cmd_wr;
        bl4    = (bl_code == BL_FOUR);
        bl_ok  = bl4 | (bl_code == BL_TWO);
        vw_bad = cmd_wr & bl4 & ~vw0 & ~vw1;
        err    = acc & (~bl_ok | vw_bad);
        wr_ok  = cmd_wr & ~err;
        if (bl4) begin
            unique case ({vw1, vw0})
                2'b01:   n_wr = CNT_W'(4);
                2'b10:   n_wr = CNT_W'(2);
                2'b11:   n_wr = CNT_W'(1);
                default: n_wr = CNT_W'(0);
            endcase
        end else begin
            n_wr = vw0 ? CNT_W'(1) : CNT_W'(2);
        end
    end

    // Per-beat offset and enable; structure repeats for every beat slot.
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        localparam logic [OFF_W-1:0] IDX = OFF_W'(b);
        always_comb begin
            if (bl4 && !burst_il)
                off_calc[b] = col_lo + IDX;
            else if (bl4)
                off_calc[b] = col_lo ^ IDX;
            else
                off_calc[b] = col_lo ^ {{(OFF_W-1){1'b0}}, IDX[0]};
            we_calc[b] = wr_ok & (CNT_W'(b) < n_wr);
        end
    end

    // Assemble the job record.
    always_comb begin
        job.valid = acc;
        job.wr    = cmd_wr;
        job.err   = err;
        job.bl4   = bl4;
        job.off   = off_calc;
        job.we    = we_calc;
    end

    // A 4-word burst must visit every word of the group exactly once.
    always_comb begin
        logic [BEATS-1:0] seen;
        seen = '0;
        for (int b = 0; b < BEATS; b++) seen[off_calc[b]] = 1'b1;
        AST_FULL_GROUP: assert (!(acc && bl4) || seen == {BEATS{1'b1}}); // R2
    end
endmodule

// File: rtl/bo_delay.sv
`timescale 1ns/1ps
// Latency line. Reads enter stage 0 and writes enter stage INS, so a read
// leaves after DEPTH clocks and a write after DEPTH-INS clocks. Assumes the
// command spacing keeps a write from landing on an occupied stage.
module bo_delay
    import bo_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int INS   = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  bo_job_t job_in,
    output bo_job_t tail
);
    bo_job_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        if (i == 0) begin : g_head
            // Head stage: accept reads, and writes too when INS is zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[0] <= '0;
                else if (job_in.valid && (!job_in.wr || INS == 0))
                    stg[0] <= job_in;
                else
                    stg[0] <= '0;
            end
        end else if (i == INS) begin : g_ins
            // Write entry stage: take a new write, otherwise shift.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= '0;
                else if (job_in.valid && job_in.wr)
                    stg[i] <= job_in;
                else
                    stg[i] <= stg[i-1];
            end
            AST_WR_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
                (job_in.valid && job_in.wr) |-> !stg[i-1].valid); // R7
        end else begin : g_shift
            // Plain shift stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign tail = stg[DEPTH-1];
endmodule

// File: rtl/bo_pair_seq.sv
`timescale 1ns/1ps
// Presents beat pairs: the first pair straight from the latency tail, the
// second pair of a 4-word burst from a one-clock holding register. Assumes
// no new job reaches the tail while a second pair is pending.
module bo_pair_seq
    import bo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bo_job_t          tail,
    output logic             beat_valid,
    output logic             beat_wr,
    output logic [OFF_W-1:0] off_a,
    output logic [OFF_W-1:0] off_b,
    output logic             we_a,
    output logic             we_b,
    output logic             cfg_err
);
    logic             pend_v;
    logic             pend_wr;
    logic [OFF_W-1:0] pend_a;
    logic [OFF_W-1:0] pend_b;
    logic             pend_we_a;
    logic             pend_we_b;

    // Hold beats 2 and 3 of a 4-word burst for the following clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_wr   <= 1'b0;
            pend_a    <= '0;
            pend_b    <= '0;
            pend_we_a <= 1'b0;
            pend_we_b <= 1'b0;
        end else begin
            pend_v    <= tail.valid & tail.bl4;
            pend_wr   <= tail.wr;
            pend_a    <= tail.off[2];
            pend_b    <= tail.off[3];
            pend_we_a <= tail.we[2];
            pend_we_b <= tail.we[3];
        end
    end

    // Choose the pair shown this clock.
    always_comb begin
        if (tail.valid) begin
            beat_valid = 1'b1;
            beat_wr    = tail.wr;
            off_a      = tail.off[0];
            off_b      = tail.off[1];
            we_a       = tail.we[0];
            we_b       = tail.we[1];
            cfg_err    = tail.err;
        end else begin
            beat_valid = pend_v;
            beat_wr    = pend_v & pend_wr;
            off_a      = pend_a;
            off_b      = pend_b;
            we_a       = pend_v & pend_we_a;
            we_b       = pend_v & pend_we_b;
            cfg_err    = 1'b0;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(tail.valid && pend_v)); // R7
    AST_ERR_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!we_a && !we_b)); // R9
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_wr) |-> (!we_a && !we_b)); // R8
    AST_MASK_TRAILING: assert property (@(posedge clk) disable iff (!rst_n)
        we_b |-> we_a); // R6
    AST_SECOND_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !tail.valid && we_a) |-> $past(we_a && we_b)); // R6
    AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (off_a != off_b)); // R2
endmodule

// File: rtl/burst_order_gen.sv
`timescale 1ns/1ps
// Burst order and write-mask generator, top level. Decodes an access on its
// strobe, delays it by the read or write latency and presents two beats per
// clock. Assumes RD_LAT >= WR_LAT >= 1 and command spacing of at least
// three clocks between accesses that would share the output.
module burst_order_gen
    import bo_pkg::*;
#(
    parameter int RD_LAT = 5,
    parameter int WR_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bl_code,
    input  logic       burst_il,
    input  logic       cmd_rd,
    input  logic       cmd_wr,
    input  logic [1:0] col_lo,
    input  logic       vw0,
    input  logic       vw1,
    output logic       beat_valid,
    output logic       beat_wr,
    output logic [1:0] off_a,
    output logic [1:0] off_b,
    output logic       we_a,
    output logic       we_b,
    output logic       cfg_err
);
    localparam int INS = RD_LAT - WR_LAT;

    bo_job_t job;
    bo_job_t tail;

    bo_decode u_dec (
        .cmd_rd   (cmd_rd),
        .cmd_wr   (cmd_wr),
        .bl_code  (bl_code),
        .burst_il (burst_il),
        .col_lo   (col_lo),
        .vw0      (vw0),
        .vw1      (vw1),
        .job      (job)
    );

    bo_delay #(.DEPTH(RD_LAT), .INS(INS)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .job_in (job),
        .tail   (tail)
    );

    bo_pair_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tail       (tail),
        .beat_valid (beat_valid),
        .beat_wr    (beat_wr),
        .off_a      (off_a),
        .off_b      (off_b),
        .we_a       (we_a),
        .we_b       (we_b),
        .cfg_err    (cfg_err)
    );
endmodule

// File: tb/burst_order_gen_test.sv
`timescale 1ns/1ps
module burst_order_gen_test;
    localparam int RDL = 5;
    localparam int WRL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bl_code = 3'b001;
    logic       burst_il = 1'b0;
    logic       cmd_rd = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [1:0] col_lo = 2'b00;
    logic       vw0 = 1'b0;
    logic       vw1 = 1'b0;
    logic       beat_valid, beat_wr, we_a, we_b, cfg_err;
    logic [1:0] off_a, off_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    burst_order_gen uut (
        .clk(clk), .rst_n(rst_n), .bl_code(bl_code), .burst_il(burst_il),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .col_lo(col_lo), .vw0(vw0), .vw1(vw1),
        .beat_valid(beat_valid), .beat_wr(beat_wr), .off_a(off_a), .off_b(off_b),
        .we_a(we_a), .we_b(we_b), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected offset of beat i, from the order rules of R2/R3.
    function automatic int exp_off(int len, bit il, int s, int i);
        if (il) return s ^ i;
        return (s & ~(len - 1)) | ((s + i) & (len - 1));
    endfunction

    // Expected count of written words, from R4/R5; -1 marks reserved.
    function automatic int exp_cnt(int len, bit v0, bit v1);
        if (len == 2) return v0 ? 1 : 2;
        if (v0 && !v1) return 4;
        if (!v0 && v1) return 2;
        if (v0 && v1) return 1;
        return -1;
    endfunction

    // Compare one presented pair against expected fields.
    task automatic chk_pair(input int len, input bit il, input int s, input bit wr,
                            input int cnt, input bit err, input int first,
                            input string otag, input string wtag);
        int ea, eb, xwa, xwb;
        chk(beat_valid === 1'b1, "R1 pair present", beat_valid, 1);
        chk(beat_wr === wr, wr ? "R7 write direction" : "R8 read direction", beat_wr, wr);
        if (len > 0) begin
            ea = exp_off(len, il, s, first);
            eb = exp_off(len, il, s, first + 1);
            chk(off_a == ea[1:0] && off_b == eb[1:0], otag, {off_a, off_b}, {ea[1:0], eb[1:0]});
        end
        xwa = (wr && !err && first < cnt) ? 1 : 0;
        xwb = (wr && !err && first + 1 < cnt) ? 1 : 0;
        chk(we_a == xwa[0] && we_b == xwb[0], wtag, {we_a, we_b}, {xwa[1:0], xwb[1:0]});
        if (first == 0)
            chk(cfg_err === err, err ? "R9 error flag" : "R1 error flag", cfg_err, err);
    endtask

    // Issue one access and check its full output window.
    task automatic run_one(input logic [2:0] blc, input bit il, input int s,
                           input bit v0, input bit v1, input bit wr);
        int len, cnt, lat;
        bit err;
        string otag, wtag;
        len = (blc == 3'b001) ? 2 : (blc == 3'b010) ? 4 : 0;
        cnt = (len == 0) ? 0 : exp_cnt(len, v0, v1);
        err = (len == 0) || (wr && cnt < 0);
        lat = wr ? WRL : RDL;
        otag = il ? "R3 interleaved offsets" : "R2 sequential offsets";
        if (len == 0) wtag = "R1 reserved length masks all";
        else if (!wr) wtag = "R8 read enables low";
        else if (err) wtag = "R9 reserved code masks all";
        else if (len == 2) wtag = "R4 two-word mask";
        else wtag = "R5/R6 four-word mask";
        @(negedge clk);
        bl_code = blc; burst_il = il; col_lo = 2'(s); vw0 = v0; vw1 = v1;
        cmd_wr = wr; cmd_rd = !wr;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_rd = 1'b0;
        repeat (lat - 2) @(negedge clk);
        chk(beat_valid === 1'b0, "R7 nothing before latency", beat_valid, 0);
        @(negedge clk);
        chk_pair(len, il, s, wr, cnt, err, 0, otag, wtag);
        @(negedge clk);
        if (len == 4) begin
            chk_pair(len, il, s, wr, cnt, err, 2, otag, wtag);
            @(negedge clk);
        end
        chk(beat_valid === 1'b0, "R1 burst ends", beat_valid, 0);
    endtask

    initial begin
        logic [2:0] codes [5];
        codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b000;
        codes[3] = 3'b011; codes[4] = 3'b110;
        repeat (3) @(negedge clk);
        chk(beat_valid === 1'b0 && we_a === 1'b0 && we_b === 1'b0 && cfg_err === 1'b0,
            "R10 outputs in reset", {beat_valid, we_a, we_b, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_valid === 1'b0 && beat_wr === 1'b0 && cfg_err === 1'b0,
            "R10 outputs after reset", {beat_valid, beat_wr, cfg_err}, 0);

        for (int c = 0; c < 5; c++)
            for (int il = 0; il < 2; il++)
                for (int s = 0; s < 4; s++)
                    for (int v = 0; v < 4; v++)
                        for (int w = 0; w < 2; w++)
                            run_one(codes[c], il[0], s, v[0], v[1], w[0]);

        // R7: read then write three clocks later, four adjacent pairs.
        @(negedge clk);
        bl_code = 3'b010; burst_il = 1'b0; col_lo = 2'd2; cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        repeat (2) @(negedge clk);
        col_lo = 2'd1; vw0 = 1'b1; vw1 = 1'b1; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        chk_pair(4, 1'b0, 2, 1'b0, 0, 1'b0, 0, "R7 mixed read offsets", "R7 mixed read enables");
        @(negedge clk);
        chk_pair(4, 1'b0, 2, 1'b0, 0, 1'b0, 2, "R7 mixed read offsets", "R7 mixed read enables");
        @(negedge clk);
        chk_pair(4, 1'b0, 1, 1'b1, 1, 1'b0, 0, "R7 mixed write offsets", "R6 mixed write enables");
        @(negedge clk);
        chk_pair(4, 1'b0, 1, 1'b1, 1, 1'b0, 2, "R7 mixed write offsets", "R6 mixed write enables");
        @(negedge clk);
        chk(beat_valid === 1'b0, "R7 mixed sequence ends", beat_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule